// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block turns a stream of input clock enables into a pixel clock waveform and a once-per-period strobe. Two candidate sources each supply a one-cycle enable pulse per input clock period. A general register picks one of them, and all counting runs on the picked pulses. The divide ratio has an integer part and a 4-bit fraction. A fractional accumulator lengthens some periods by one input tick, so that the long-run average ratio comes out exact.

Within each divided period, the rising and falling positions of the output are programmed independently, in units of half an input period. A polarity bit inverts the finished waveform. Software writes the divider and edge registers at any time. Those writes are held pending and only take effect at the next period boundary, so a period already running is never cut short or stretched.

Top module: `pixclk_frac_div`

## Requirements
- R1: After reset, pix_clk_o and pix_stb_o are 0, the edge positions are 0, and the divider holds 0x10 (divide by one), so every selected tick starts a new period.
- R2: General register (address 0) bit 20 selects the source: 1 selects ext_tick_i and 0 selects int_tick_i. Pulses on the source that is not selected have no effect on either output.
- R3: The integer divider D is bits 11:4 of the divider register (address 1). An integer field of 0 is treated as 1. With a zero fraction, every period lasts D selected ticks.
- R4: Bits 3:0 of the divider register are a fraction F. Each period adds F to a 4-bit accumulator, and a carry out lengthens that period by one tick, so any 16 consecutive periods from reset total 16*D+F ticks.
- R5: pix_stb_o is high for exactly the one clock cycle that follows the selected tick starting a period. It is never high at any other time.
- R6: The edge register (address 2) holds the rise position in bits 8:0 and the fall position in bits 24:16, both counted in half input periods. During the k-th tick of a period (k from 0), the uninverted level is 1 when rise <= 2k < fall. The level updates in the cycle after that tick.
- R7: General register bit 17 inverts pix_clk_o, starting in the cycle after the write.
- R8: A write to the divider or the edge register leaves the period in progress unchanged. The new value first applies to the period that starts at the next boundary.
- R9: Outputs change only in the cycle after a selected tick. Without a tick, the waveform level and the phase hold, and the strobe is low.
- R10: A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_tick_i | input | 1 | Enable pulse of the internal bus clock source |
| ext_tick_i | input | 1 | Enable pulse of the external display clock source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 general, 1 divider, 2 edges, 3 none |
| wr_data_i | input | 32 | Register write data |
| pix_clk_o | output | 1 | Divided pixel clock waveform, polarity applied |
| pix_stb_o | output | 1 | One-cycle strobe at the start of each divided period |

## Verification
The hardest behaviour to reach is the interplay between the fractional carry and the boundary-timed loading of pending values. A carry lengthens a period only occasionally, and a write that lands in the middle of a period must not disturb it. The bench sweeps every combination of several integer ratios (including a zero field) with fractions 0, 1, 5, 8 and 15. It drives both sources with different, irregular pulse patterns, so a wrong source choice shows up at once. Over sixteen periods it adds up the tick totals. A separate sequence writes a new ratio partway through a period and counts the ticks until the next strobe.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    typedef enum logic [1:0] {
        REG_GEN  = 2'd0,
        REG_DIV  = 2'd1,
        REG_EDGE = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    localparam int GEN_SEL_BIT = 20;
    localparam int GEN_POL_BIT = 17;
    localparam int FALL_LSB    = 16;

endpackage

// File: rtl/pcd_regs.sv
module pcd_regs
    import pcd_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    parameter int EDGE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              boundary,
    output logic              src_ext,
    output logic              out_inv,
    output logic [INT_W-1:0]  pend_int,
    output logic [FRAC_W-1:0] pend_frac,
    output logic [EDGE_W-1:0] rise,
    output logic [EDGE_W-1:0] fall
);
    localparam int DIV_W = INT_W + FRAC_W;

    typedef struct packed {
        logic              sel;
        logic              inv;
        logic [DIV_W-1:0]  div;
        logic [EDGE_W-1:0] p_rise;
        logic [EDGE_W-1:0] p_fall;
        logic [EDGE_W-1:0] a_rise;
        logic [EDGE_W-1:0] a_fall;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (boundary) begin
            st_d.a_rise = st_q.p_rise;
            st_d.a_fall = st_q.p_fall;
        end
        if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_GEN: begin
                    st_d.sel = wr_data[GEN_SEL_BIT];
                    st_d.inv = wr_data[GEN_POL_BIT];
                end
                REG_DIV:  st_d.div = wr_data[DIV_W-1:0];
                REG_EDGE: begin
                    st_d.p_rise = wr_data[EDGE_W-1:0];
                    st_d.p_fall = wr_data[FALL_LSB +: EDGE_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.div    <= DIV_W'(1) << FRAC_W;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_ext   = st_q.sel;
    assign out_inv   = st_q.inv;
    assign pend_int  = st_q.div[DIV_W-1:FRAC_W];
    assign pend_frac = st_q.div[FRAC_W-1:0];
    assign rise      = boundary ? st_q.p_rise : st_q.a_rise;
    assign fall      = boundary ? st_q.p_fall : st_q.a_fall;

endmodule

// File: rtl/pcd_phase.sv
module pcd_phase #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    parameter int CNT_W  = INT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [INT_W-1:0]  pend_int,
    input  logic [FRAC_W-1:0] pend_frac,
    output logic              boundary,
    output logic [CNT_W-1:0]  phase_nxt,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  len,
    output logic              stb
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  len;
        logic [FRAC_W-1:0] acc;
        logic              stb;
    } phase_t;

    phase_t st_d, st_q;

    logic             last;
    logic [INT_W-1:0] int_eff;
    logic [FRAC_W:0]  acc_sum;

    always_comb begin
        last     = (st_q.cnt == st_q.len - CNT_W'(1));
        boundary = tick && last;
        int_eff  = (pend_int == '0) ? INT_W'(1) : pend_int;
        acc_sum  = {1'b0, st_q.acc} + {1'b0, pend_frac};

        st_d     = st_q;
        st_d.stb = 1'b0;
        if (tick) begin
            if (last) begin
                st_d.cnt = '0;
                st_d.acc = acc_sum[FRAC_W-1:0];
                st_d.len = CNT_W'(int_eff) + CNT_W'(acc_sum[FRAC_W]);
                st_d.stb = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        phase_nxt = st_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.len <= CNT_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign len = st_q.len;
    assign stb = st_q.stb;

endmodule

// File: rtl/pcd_wave.sv
module pcd_wave #(
    parameter int CNT_W  = 9,
    parameter int EDGE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CNT_W-1:0]  phase_nxt,
    input  logic [EDGE_W-1:0] rise,
    input  logic [EDGE_W-1:0] fall,
    output logic              level
);
    localparam int CMP_W = (CNT_W + 1 > EDGE_W) ? CNT_W + 1 : EDGE_W;

    typedef struct packed {
        logic level;
    } wave_t;

    wave_t st_d, st_q;

    logic [CMP_W-1:0] half_pos;
    logic [CMP_W-1:0] rise_x;
    logic [CMP_W-1:0] fall_x;

    always_comb begin
        half_pos = CMP_W'({phase_nxt, 1'b0});
        rise_x   = CMP_W'(rise);
        fall_x   = CMP_W'(fall);
        st_d     = st_q;
        if (tick) begin
            st_d.level = (rise_x <= half_pos) && (half_pos < fall_x);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;

endmodule

// File: rtl/pixclk_frac_div.sv
module pixclk_frac_div #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    parameter int EDGE_W = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        int_tick_i,
    input  logic        ext_tick_i,
    input  logic        wr_en_i,
    input  logic [1:0]  wr_addr_i,
    input  logic [31:0] wr_data_i,
    output logic        pix_clk_o,
    output logic        pix_stb_o
);
    localparam int CNT_W = INT_W + 1;

    logic              src_ext;
    logic              out_inv;
    logic [INT_W-1:0]  pend_int;
    logic [FRAC_W-1:0] pend_frac;
    logic [EDGE_W-1:0] rise;
    logic [EDGE_W-1:0] fall;
    logic              boundary;
    logic [CNT_W-1:0]  phase_nxt;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  len_q;
    logic              stb;
    logic              level;
    logic              tick;

    assign tick = src_ext ? ext_tick_i : int_tick_i;

    pcd_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .EDGE_W(EDGE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_i),
        .wr_addr   (wr_addr_i),
        .wr_data   (wr_data_i),
        .boundary  (boundary),
        .src_ext   (src_ext),
        .out_inv   (out_inv),
        .pend_int  (pend_int),
        .pend_frac (pend_frac),
        .rise      (rise),
        .fall      (fall)
    );

    pcd_phase #(.INT_W(INT_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pend_int  (pend_int),
        .pend_frac (pend_frac),
        .boundary  (boundary),
        .phase_nxt (phase_nxt),
        .cnt       (cnt_q),
        .len       (len_q),
        .stb       (stb)
    );

    pcd_wave #(.CNT_W(CNT_W), .EDGE_W(EDGE_W)) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .phase_nxt (phase_nxt),
        .rise      (rise),
        .fall      (fall),
        .level     (level)
    );

    assign pix_clk_o = level ^ out_inv;
    assign pix_stb_o = stb;

endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             stb,
    input logic             level,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] len
);
    AST_STB_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> $past(tick)); // R5
    AST_STB_AT_PHASE0: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> (cnt == '0)); // R5
    AST_PHASE_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < len); // R3
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (len != '0) && (len <= CNT_W'(1) << (CNT_W - 1))); // R4
    AST_IDLE_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (!stb && $stable(cnt))); // R9
    AST_IDLE_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(level)); // R9
endmodule

bind pixclk_frac_div pcd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .stb   (pix_stb_o),
    .level (level),
    .cnt   (cnt_q),
    .len   (len_q)
);

// File: tb/pixclk_frac_div_bench.sv
module pixclk_frac_div_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        pix_clk_o;
    logic        pix_stb_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // bench-side expectations
    int m_pd, m_pf, m_pr, m_pfl, m_ar, m_afl;
    int m_cnt, m_len, m_acc;
    bit m_sel, m_pol, m_level, m_stb;
    int nstb, tcnt, tcap;

    pixclk_frac_div u_pixclk_frac_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_tick_i (int_tick),
        .ext_tick_i (ext_tick),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .pix_clk_o  (pix_clk_o),
        .pix_stb_o  (pix_stb_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare_outputs(input string tag);
        check(pix_clk_o === (m_level ^ m_pol), {tag, " R6 pix_clk"}, int'(pix_clk_o), int'(m_level ^ m_pol));
        check(pix_stb_o === m_stb, {tag, " R5 pix_stb"}, int'(pix_stb_o), int'(m_stb));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_pd = 1; m_pf = 0; m_pr = 0; m_pfl = 0; m_ar = 0; m_afl = 0;
        m_cnt = 0; m_len = 1; m_acc = 0;
        m_sel = 1'b0; m_pol = 1'b0; m_level = 1'b0; m_stb = 1'b0;
        nstb = 0; tcnt = 0; tcap = -1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        case (a)
            2'd0: begin m_sel = d[20]; m_pol = d[17]; end
            2'd1: begin m_pd = int'(d[11:4]); m_pf = int'(d[3:0]); end
            2'd2: begin m_pr = int'(d[8:0]); m_pfl = int'(d[24:16]); end
            default: ;
        endcase
        m_stb = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        compare_outputs("R7 R10 write");
    endtask

    task automatic step(input logic ie, input logic ee);
        bit t;
        int deff, sum;
        int_tick = ie; ext_tick = ee;
        t = m_sel ? ee : ie;
        @(posedge clk);
        m_stb = 1'b0;
        if (t) begin
            if (m_cnt == m_len - 1) begin
                deff = (m_pd == 0) ? 1 : m_pd;
                sum = m_acc + m_pf;
                m_len = deff + (sum >= 16 ? 1 : 0);
                m_acc = sum % 16;
                m_cnt = 0;
                m_ar = m_pr; m_afl = m_pfl;
                m_stb = 1'b1;
            end else begin
                m_cnt++;
            end
            m_level = (m_ar <= 2 * m_cnt) && (2 * m_cnt < m_afl);
        end
        @(negedge clk);
        int_tick = 1'b0; ext_tick = 1'b0;
        compare_outputs("R2 R9 step");
        if (t) begin
            if (pix_stb_o) begin
                nstb++;
                if (nstb == 1) tcnt = 0;
                if (nstb == 17) tcap = tcnt;
            end
            tcnt++;
        end
    endtask

    initial begin
        int dv[5] = '{0, 1, 2, 3, 5};
        int fv[5] = '{0, 1, 5, 8, 15};
        int gap;
        int seen;

        do_reset();
        // R1 reset state
        check(pix_clk_o === 1'b0, "R1 reset pix_clk", int'(pix_clk_o), 0);
        check(pix_stb_o === 1'b0, "R1 reset pix_stb", int'(pix_stb_o), 0);
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0);
            check(pix_stb_o === 1'b1, "R1 divide by one strobe", int'(pix_stb_o), 1);
        end

        // R2: external selected, only internal pulses arrive
        wr(2'd0, 32'h0010_0000);
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 1'b0);
            if (pix_stb_o) seen++;
        end
        check(seen == 0, "R2 unselected source ignored", seen, 0);

        // R3 R4 R6 R7 sweep
        foreach (dv[i]) begin
            foreach (fv[j]) begin
                int d, f, deff, rs, fl;
                bit sl, pl;
                d = dv[i]; f = fv[j];
                deff = (d == 0) ? 1 : d;
                rs = f % 3;
                fl = deff + (f & 1);
                sl = d[0];
                pl = f[3];
                do_reset();
                wr(2'd0, (32'(sl) << 20) | (32'(pl) << 17));
                wr(2'd1, 32'((d << 4) | f));
                wr(2'd2, 32'((fl << 16) | rs));
                for (int c = 0; c < 3000 && nstb < 17; c++) begin
                    step(logic'(c % 3 != 2), logic'(c % 2 == 0));
                end
                check(tcap == 16 * deff + f, "R3 R4 sixteen period total", tcap, 16 * deff + f);
            end
        end

        // R3: largest integer ratio
        do_reset();
        wr(2'd1, 32'd255 << 4);
        wr(2'd2, (32'd255 << 16));
        gap = -1;
        seen = 0;
        for (int c = 0; c < 700 && seen < 3; c++) begin
            step(1'b1, 1'b0);
            if (pix_stb_o) begin
                seen++;
                if (seen == 3) gap = tcnt;
            end
        end
        check(gap == 2 * 255 + 1, "R3 divide by 255 spacing", gap, 2 * 255 + 1);

        // R8: divider write mid period
        do_reset();
        wr(2'd1, 32'd4 << 4);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        wr(2'd1, 32'd2 << 4);
        wr(2'd2, 32'h0001_0000);
        gap = 0;
        for (int c = 0; c < 10; c++) begin
            step(1'b1, 1'b0);
            gap++;
            if (pix_stb_o) break;
        end
        check(gap == 3, "R8 old period completes", gap, 3);
        gap = 0;
        for (int c = 0; c < 10; c++) begin
            step(1'b1, 1'b0);
            gap++;
            if (pix_stb_o) break;
        end
        check(gap == 2, "R8 new ratio applies", gap, 2);

        // R10: address 3 is ignored
        wr(2'd3, 32'hFFFF_FFFF);
        for (int c = 0; c < 8; c++) step(1'b1, 1'b1);
        check(pix_clk_o === (m_level ^ m_pol), "R10 ignored address", int'(pix_clk_o), int'(m_level ^ m_pol));

        // R7: polarity flip while idle
        wr(2'd0, 32'h0002_0000);
        check(pix_clk_o === ~m_level, "R7 inverted output", int'(pix_clk_o), int'(~m_level));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule